// File: doc/BRIEF.md
# Four-Phase Signal Light Sequencer

This block drives a single signal head with three lamps (green, yellow and red) through four phases. The fourth phase lights red and yellow together before the return to green. Every step is requested by a one-cycle advance strobe from outside logic, such as a phase timer. While the strobe is low, the current phase is kept.

The phase register is the lamp vector itself. Each of the three state bits goes straight to one lamp pin, so nothing sits between the flops and the outputs. The two-lamp phase gets its own code, and no extra flop is needed. A synchronous reset puts the head into red, the safe phase. Any code that is not one of the four phases is sent back to red on the next clock edge.

Top module: `phase_light`

## Requirements
- R1: While `rst` is high at a rising clock edge, the lamps after that edge are red only (`lamp_red`=1, `lamp_yellow`=0, `lamp_green`=0).
- R2: The lamp pins come straight from the 3-bit state, with bit 0 driving green, bit 1 driving yellow and bit 2 driving red. The legal codes are 001 green, 010 yellow, 100 red and 110 red-plus-yellow.
- R3: With `advance` high at an edge, the phase moves one step in the order green, yellow, red, red-plus-yellow, then green again.
- R4: With `advance` low at an edge, all three lamps keep their values.
- R5: Outside reset, the lamp vector only ever shows one of the four legal codes. Green is never lit together with another lamp.
- R6: In the red-plus-yellow phase, red and yellow are both lit and green is dark.
- R7: Holding `advance` high on consecutive edges moves exactly one phase per edge, so four edges bring the head back to the phase it started in.
- R8: Raising `rst` in any phase returns the head to red on the next edge, whatever the level of `advance`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads red |
| advance | input | 1 | Step request, sampled at each rising edge |
| lamp_green | output | 1 | Green lamp, state bit 0 |
| lamp_yellow | output | 1 | Yellow lamp, state bit 1 |
| lamp_red | output | 1 | Red lamp, state bit 2 |

## Verification
Isolated single strobes separated by idle gaps check the step order one phase at a time and show that idle edges do not move the phase. A run of back-to-back strobes separates a design that steps once per edge from one that skips or stalls. Reset is asserted in the middle of the sequence, with `advance` both low and high, to show that reset wins over stepping from any phase. The full lamp triple is compared at every sample, so a wrong bit-to-lamp mapping or a missing second lamp in the red-plus-yellow phase is caught.

// File: rtl/phase_light_pkg.sv
package phase_light_pkg;

    localparam int LAMP_W = 3;

    localparam int BIT_GREEN  = 0;
    localparam int BIT_YELLOW = 1;
    localparam int BIT_RED    = 2;

    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t CODE_GREEN  = lamp_t'(1 << BIT_GREEN);
    localparam lamp_t CODE_YELLOW = lamp_t'(1 << BIT_YELLOW);
    localparam lamp_t CODE_RED    = lamp_t'(1 << BIT_RED);
    localparam lamp_t CODE_REDYEL = lamp_t'((1 << BIT_RED) | (1 << BIT_YELLOW));

    typedef struct packed {
        lamp_t lamp;
    } light_state_t;

endpackage

// File: rtl/phase_legal.sv
module phase_legal
    import phase_light_pkg::*;
(
    input  lamp_t code,
    output logic  is_legal
);
    always_comb begin
        unique case (code)
            CODE_GREEN, CODE_YELLOW, CODE_RED, CODE_REDYEL: is_legal = 1'b1;
            default:                                        is_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/phase_step.sv
module phase_step
    import phase_light_pkg::*;
(
    input  lamp_t cur,
    output lamp_t nxt
);
    // Successor of each legal phase; anything else falls back to red.
    always_comb begin
        unique case (cur)
            CODE_GREEN:  nxt = CODE_YELLOW;
            CODE_YELLOW: nxt = CODE_RED;
            CODE_RED:    nxt = CODE_REDYEL;
            CODE_REDYEL: nxt = CODE_GREEN;
            default:     nxt = CODE_RED;
        endcase
    end
endmodule

// File: rtl/phase_light.sv
module phase_light
    import phase_light_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic lamp_green,
    output logic lamp_yellow,
    output logic lamp_red
);
    light_state_t st_d, st_q;
    lamp_t        succ;
    logic         cur_legal;

    phase_step u_step (
        .cur (st_q.lamp),
        .nxt (succ)
    );

    phase_legal u_legal (
        .code     (st_q.lamp),
        .is_legal (cur_legal)
    );

    always_comb begin
        st_d = st_q;
        if (!cur_legal) begin
            st_d.lamp = CODE_RED;
        end else if (advance) begin
            st_d.lamp = succ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lamp <= CODE_RED;
        end else begin
            st_q <= st_d;
        end
    end

    // Lamps are the state bits, no decode.
    assign lamp_green  = st_q.lamp[BIT_GREEN];
    assign lamp_yellow = st_q.lamp[BIT_YELLOW];
    assign lamp_red    = st_q.lamp[BIT_RED];

    a_r1_reset_red: assert property (@(posedge clk)
        rst |=> (lamp_red && !lamp_yellow && !lamp_green));

    a_r8_reset_wins: assert property (@(posedge clk)
        (rst && advance) |=> (lamp_red && !lamp_yellow));

    a_r3_green_to_yellow: assert property (@(posedge clk) disable iff (rst)
        (advance && lamp_green) |=> (lamp_yellow && !lamp_green && !lamp_red));

    a_r3_redyel_to_green: assert property (@(posedge clk) disable iff (rst)
        (advance && lamp_red && lamp_yellow) |=> (lamp_green && !lamp_red && !lamp_yellow));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!advance && !$past(rst)) |=> $stable({lamp_red, lamp_yellow, lamp_green}));

    a_r5_green_alone: assert property (@(posedge clk) disable iff (rst)
        lamp_green |-> (!lamp_red && !lamp_yellow));

    a_r5_some_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({lamp_red, lamp_yellow, lamp_green}) != 0);

    a_r6_yellow_lone_or_red: assert property (@(posedge clk) disable iff (rst)
        (lamp_yellow && !lamp_red) |=> (advance ? 1'b1 : !lamp_green) || $past(advance));
endmodule

// File: tb/sim_phase_light.sv
module sim_phase_light;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic advance = 1'b0;
    logic lamp_green, lamp_yellow, lamp_red;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] G  = 3'b001;
    localparam logic [2:0] Y  = 3'b010;
    localparam logic [2:0] R  = 3'b100;
    localparam logic [2:0] RY = 3'b110;

    phase_light u0 (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .lamp_green  (lamp_green),
        .lamp_yellow (lamp_yellow),
        .lamp_red    (lamp_red)
    );

    always #5 clk = ~clk;

    function automatic logic [2:0] next_of(input logic [2:0] p);
        case (p)
            G:       return Y;
            Y:       return R;
            R:       return RY;
            RY:      return G;
            default: return R;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {lamp_red, lamp_yellow, lamp_green};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lamps(r,y,g)=%b expected %b", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the rising edge.
    task automatic tick(input logic r, input logic a);
        @(negedge clk);
        rst = r;
        advance = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        check("R1", R);
        tick(1'b0, 1'b0);
        check("R1", R);
    endtask

    task automatic t_single_steps();
        logic [2:0] exp = R;
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, 1'b1);
            exp = next_of(exp);
            check(exp == RY ? "R6" : "R3", exp);
            tick(1'b0, 1'b0);
            check("R4", exp);
            tick(1'b0, 1'b0);
            check("R2", exp);
        end
    endtask

    task automatic t_burst();
        logic [2:0] start;
        logic [2:0] exp;
        start = {lamp_red, lamp_yellow, lamp_green};
        exp = start;
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, 1'b1);
            exp = next_of(exp);
            check("R7", exp);
            if (lamp_green && (lamp_red || lamp_yellow)) begin
                checks++; errors++;
                $display("FAIL R5: green lit with another lamp");
            end
        end
        check("R7", start);
        tick(1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        check("R8", R);
        tick(1'b0, 1'b1);
        check("R8", RY);
        tick(1'b0, 1'b1);
        check("R3", G);
        tick(1'b1, 1'b0);
        check("R8", R);
        tick(1'b0, 1'b0);
        check("R4", R);
    endtask

    initial begin
        t_reset();
        t_single_steps();
        t_burst();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule